// File: doc/BRIEF.md
# Fault-Tolerant Redundant Serial Receiver

This block receives asynchronous serial frames (one low start bit, eight data bits, one high stop bit) from a single raw line and delivers each good byte with a one-cycle strobe. The consumer can act on every byte as it arrives, so no buffering is needed. The line passes through a two-flop synchronizer. A falling edge is seen when the previous synchronized sample was high and the current one is low.

Each falling edge may start one of several capture engines. The engines start in order, and while earlier engines are still counting, a later edge starts the lowest free engine. So a spurious low pulse cannot swallow the real frame that follows it. Every bit is sampled three times. A bit is trusted only if all three samples agree. Engines report in the order they were started, and a frame is accepted only from an engine whose stop bit reads high and whose bits all agreed. The first such engine wins and cancels all the others. When every started engine has failed, all engines are released together.

Top module: `redundant_uart_rx`

## Requirements
- R1: A clean frame (start bit 0, data bits least significant first, stop bit 1) sets rx_data_o to the transmitted byte and gives one valid_o pulse.
- R2: valid_o is high for exactly one clock, in the same cycle as rx_data_o takes the new byte. That cycle is exactly 9*CLKS_PER_BIT + floor(5*CLKS_PER_BIT/6) + 3 clocks after the rx_i change that opens the start bit.
- R3: An engine whose stop bit does not read high produces nothing, and the decision passes to the next engine in start order. If a later engine was started by a falling edge inside the failed frame and its own stop position reads high, it delivers the bits it captured.
- R4: Each bit is sampled floor(CLKS_PER_BIT/6), floor(CLKS_PER_BIT/2) and floor(5*CLKS_PER_BIT/6) clocks after the bit begins. If any bit of an engine has samples that differ, that engine delivers nothing, even with a high stop bit.
- R5: Once a frame is accepted, all other engines are cancelled. A clean frame yields exactly one byte, even when its data holds falling edges.
- R6: A falling edge that does not lead to a valid frame does not prevent the real frame that follows it from being received.
- R7: At most NUM_PATHS captures are in flight. Running engines and failed engines awaiting release both count as busy. A falling edge that arrives while no engine is free is ignored.
- R8: If the last running engine fails in the same cycle as a falling edge is detected, all engines are released and that edge starts a new capture.
- R9: After reset, rx_data_o is 0 and valid_o is 0. rx_data_o holds its value between accepted frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Raw asynchronous serial line, idle high |
| rx_data_o | output | 8 | Last accepted byte |
| valid_o | output | 1 | One-cycle strobe when rx_data_o is updated |

## Verification
Two things can land in the same cycle: the failure of the last running engine, which releases every engine, and the detection of a new falling edge. The bench provokes this with an all-zero frame whose stop bit stays high for only the first two sample points. The line drops exactly at the third stop sample, and that drop is the start bit of a second frame. The second byte must appear exactly one frame latency after its start edge, which is only possible if the release and the new start were both honoured in that one cycle. Sweeps over all byte values, both with good stop bits and with stop bits forced low, are compared against a bit-level model of which engine wins.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int BIDX_W     = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    PATH_IDLE  = 2'd0,
    PATH_RUN   = 2'd1,
    PATH_SPENT = 2'd2
  } path_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rx_s_o = s2_q;
  assign fall_o = prev_q & ~s2_q;
endmodule

// File: rtl/urx_path.sv
module urx_path
  import urx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_s_i,
  input  logic              arm_i,
  input  logic              clear_i,
  output logic              idle_o,
  output logic              run_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] PT_A    = CW'(CLKS_PER_BIT / 6);
  localparam logic [CW-1:0] PT_B    = CW'(CLKS_PER_BIT / 2);
  localparam logic [CW-1:0] PT_C    = CW'((5 * CLKS_PER_BIT) / 6);
  localparam logic [CW-1:0] CNT_MAX = CW'(CLKS_PER_BIT - 1);
  localparam logic [BIDX_W-1:0] STOP_IDX = BIDX_W'(FRAME_BITS - 1);

  path_state_e       state_q;
  logic [CW-1:0]     cnt_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              smp_a_q, smp_b_q, err_q;
  logic [DATA_W-1:0] shift_q;
  logic              at_c, vote_bad;

  assign at_c     = (state_q == PATH_RUN) && (cnt_q == PT_C);
  assign vote_bad = at_c && !((smp_a_q == smp_b_q) && (smp_b_q == rx_s_i));
  assign done_o   = at_c && (bidx_q == STOP_IDX);
  assign ok_o     = done_o && !err_q && !vote_bad && rx_s_i;
  assign idle_o   = (state_q == PATH_IDLE);
  assign run_o    = (state_q == PATH_RUN);
  assign data_o   = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PATH_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      smp_a_q <= 1'b0;
      smp_b_q <= 1'b0;
      err_q   <= 1'b0;
      shift_q <= '0;
    end else if (arm_i) begin
      // edge cycle counts as offset 0 of the start bit
      state_q <= PATH_RUN;
      cnt_q   <= CW'(1);
      bidx_q  <= '0;
      err_q   <= 1'b0;
    end else if (clear_i) begin
      state_q <= PATH_IDLE;
    end else if (done_o) begin
      state_q <= PATH_SPENT;
    end else if (state_q == PATH_RUN) begin
      if (cnt_q == CNT_MAX) begin
        cnt_q  <= '0;
        bidx_q <= bidx_q + BIDX_W'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (cnt_q == PT_A) smp_a_q <= rx_s_i;
      if (cnt_q == PT_B) smp_b_q <= rx_s_i;
      if (vote_bad) err_q <= 1'b1;
      if (at_c && bidx_q != '0) shift_q <= {rx_s_i, shift_q[DATA_W-1:1]};
    end
  end
endmodule

// File: rtl/urx_arbiter.sv
module urx_arbiter #(
  parameter int NUM_PATHS = 10
) (
  input  logic [NUM_PATHS-1:0] idle_i,
  input  logic [NUM_PATHS-1:0] run_i,
  input  logic [NUM_PATHS-1:0] done_i,
  input  logic [NUM_PATHS-1:0] ok_i,
  input  logic                 fall_i,
  output logic [NUM_PATHS-1:0] arm_o,
  output logic [NUM_PATHS-1:0] win_o,
  output logic                 clear_o
);
  logic [NUM_PATHS-1:0] cand, first_idle, target, live_after;
  logic                 any_win, all_fail;

  // lowest set bit = earliest started engine
  assign cand       = done_i & ok_i;
  assign win_o      = cand & (~cand + NUM_PATHS'(1));
  assign first_idle = idle_i & (~idle_i + NUM_PATHS'(1));
  assign any_win    = |win_o;
  assign live_after = run_i & ~done_i;
  assign all_fail   = (|done_i) && !(|live_after) && !any_win;
  assign clear_o    = any_win || all_fail;
  assign target     = clear_o ? NUM_PATHS'(1) : first_idle;
  assign arm_o      = fall_i ? target : '0;
endmodule

// File: rtl/redundant_uart_rx.sv
module redundant_uart_rx
  import urx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int NUM_PATHS    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              valid_o
);
  logic                 rx_s, fall, clear;
  logic [NUM_PATHS-1:0] idle_vec, run_vec, done_vec, ok_vec, arm_vec, win_vec;
  logic [DATA_W-1:0]    path_data [NUM_PATHS];
  logic [DATA_W-1:0]    sel_data;

  urx_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_s_o (rx_s),
    .fall_o (fall)
  );

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    urx_path #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_path (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rx_s_i  (rx_s),
      .arm_i   (arm_vec[g]),
      .clear_i (clear),
      .idle_o  (idle_vec[g]),
      .run_o   (run_vec[g]),
      .done_o  (done_vec[g]),
      .ok_o    (ok_vec[g]),
      .data_o  (path_data[g])
    );
  end

  urx_arbiter #(.NUM_PATHS(NUM_PATHS)) u_arb (
    .idle_i  (idle_vec),
    .run_i   (run_vec),
    .done_i  (done_vec),
    .ok_i    (ok_vec),
    .fall_i  (fall),
    .arm_o   (arm_vec),
    .win_o   (win_vec),
    .clear_o (clear)
  );

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NUM_PATHS; i++) begin
      if (win_vec[i]) sel_data = sel_data | path_data[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= |win_vec;
      if (|win_vec) rx_data_o <= sel_data;
    end
  end
endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
  parameter int NP = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_i,
  input logic          rx_s_i,
  input logic          fall_i,
  input logic [NP-1:0] run_i,
  input logic [NP-1:0] win_i,
  input logic          valid_i,
  input logic [7:0]    data_i
);
  AST_FLAG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i); // R2

  AST_SYNC_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_s_i) |-> !$past(rx_i, 2)); // R2

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i)); // R9

  AST_SINGLE_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_i)); // R5

  AST_VALID_FROM_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(|win_i)); // R1

  AST_NEW_PATH_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(run_i & ~$past(run_i)) |-> $past(fall_i)); // R6

  AST_ARM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(run_i) <= $countones($past(run_i)) + 1); // R7
endmodule

bind redundant_uart_rx urx_checker #(.NP(NUM_PATHS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rx_i    (rx_i),
  .rx_s_i  (rx_s),
  .fall_i  (fall),
  .run_i   (run_vec),
  .win_i   (win_vec),
  .valid_i (valid_o),
  .data_i  (rx_data_o)
);

// File: tb/redundant_uart_rx_test.sv
module redundant_uart_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPB = 12;
  localparam int NP  = 10;
  localparam int LAT = 9 * CPB + (5 * CPB) / 6 + 3;
  localparam int SA  = CPB / 6;
  localparam int SB  = CPB / 2;
  localparam int SC  = (5 * CPB) / 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [7:0] rx_data;
  logic       valid;

  int checks = 0, errors = 0, cyc = 0, got_n = 0;
  bit fin = 1'b0, prev_v = 1'b0;
  logic [7:0] got_d [0:2047];
  int         got_c [0:2047];

  redundant_uart_rx #(.CLKS_PER_BIT(CPB), .NUM_PATHS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_data_o(rx_data), .valid_o(valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        checks++;
        if (prev_v) begin
          errors++;
          $display("FAIL R2: valid_o width actual >1 expected 1");
        end
        if (got_n < 2048) begin
          got_d[got_n] = rx_data;
          got_c[got_n] = cyc;
        end
        got_n++;
      end
      prev_v = valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] b, input logic stop);
    logic [31:0] ln = '1;
    ln[0]   = 1'b0;
    ln[8:1] = b;
    ln[9]   = stop;
    return ln;
  endfunction

  // bit-level model: first started engine whose stop position is high wins
  task automatic ref_pick(input logic [31:0] ln, output bit f, output logic [7:0] b);
    f = 1'b0;
    b = '0;
    for (int e = 0; e <= 22; e++) begin
      logic prev = (e == 0) ? 1'b1 : ln[e-1];
      if (!f && prev && !ln[e] && ln[e+9]) begin
        f = 1'b1;
        for (int i = 0; i < 8; i++) b[i] = ln[e+1+i];
      end
    end
  endtask

  task automatic send(input logic [31:0] ln, input int nb, output int st);
    st = cyc;
    for (int p = 0; p < nb; p++) begin
      rx = ln[p];
      repeat (CPB) @(negedge clk);
    end
  endtask

  task automatic send_pulse(input logic [31:0] ln, input int nb, input int pb, input int ps);
    for (int p = 0; p < nb; p++) begin
      for (int c = 0; c < CPB; c++) begin
        rx = (p == pb && c >= ps - 1 && c <= ps + 1) ? 1'b0 : ln[p];
        @(negedge clk);
      end
    end
  endtask

  task automatic glitch;
    rx = 1'b0;
    @(negedge clk);
    rx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int st, base, n;
    bit f;
    logic [7:0] eb;
    logic [7:0] gl [4] = '{8'h00, 8'h3C, 8'hA5, 8'hFF};
    int pts [3];
    pts[0] = SA; pts[1] = SB; pts[2] = SC;

    repeat (5) @(negedge clk);
    check(valid == 1'b0, "R9 reset valid", int'(valid), 0);
    check(rx_data == 8'h00, "R9 reset data", int'(rx_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R5: every byte, clean frames
    for (int b = 0; b < 256; b++) begin
      base = got_n;
      send(mk(8'(b), 1'b1), 11, st);
      n = got_n - base;
      check(n == 1, "R5 one byte per frame", n, 1);
      if (n >= 1) begin
        check(got_d[base] == 8'(b), "R1 data", int'(got_d[base]), b);
        check(got_c[base] - st == LAT, "R2 latency", got_c[base] - st, LAT);
      end
    end

    // R3: stop bit low, later engine decides
    for (int b = 0; b < 256; b++) begin
      logic [31:0] ln = mk(8'(b), 1'b0);
      ref_pick(ln, f, eb);
      base = got_n;
      send(ln, 22, st);
      n = got_n - base;
      check(n == (f ? 1 : 0), "R3 count", n, f ? 1 : 0);
      if (f && n >= 1) check(got_d[base] == eb, "R3 data", int'(got_d[base]), int'(eb));
    end

    // R4: one disturbed sample per bit, then hold check (R9)
    base = got_n;
    send(mk(8'h96, 1'b1), 11, st);
    check(got_n - base == 1 && got_d[base] == 8'h96, "R1 pre-hold", int'(rx_data), 'h96);
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 3; k++) begin
        base = got_n;
        send_pulse(mk(8'hFF, 1'b1), 23, i + 1, pts[k]);
        n = got_n - base;
        check(n == 0, "R4 vote reject", n, 0);
      end
    end
    check(rx_data == 8'h96, "R9 hold", int'(rx_data), 'h96);

    // R6: false start before a real frame
    for (int j = 0; j < 4; j++) begin
      base = got_n;
      glitch();
      send(mk(gl[j], 1'b1), 11, st);
      repeat (12 * CPB) @(negedge clk);
      n = got_n - base;
      check(n == 1, "R6 count", n, 1);
      if (n >= 1) begin
        check(got_d[base] == gl[j], "R6 data", int'(got_d[base]), int'(gl[j]));
        check(got_c[base] - st == LAT, "R6 latency", got_c[base] - st, LAT);
      end
    end

    // R7: all engines busy, frame start ignored
    base = got_n;
    for (int j = 0; j < NP; j++) glitch();
    send(mk(8'h5A, 1'b1), 11, st);
    repeat (15 * CPB) @(negedge clk);
    n = got_n - base;
    check(n == 0, "R7 busy ignored", n, 0);
    base = got_n;
    send(mk(8'h81, 1'b1), 11, st);
    n = got_n - base;
    check(n == 1 && got_d[base] == 8'h81, "R7 recovery", int'(rx_data), 'h81);

    // R8: last engine fails in the cycle a new edge arrives
    base = got_n;
    send(mk(8'h00, 1'b1), 9, st);
    rx = 1'b1;
    repeat (SC) @(negedge clk);
    send(mk(8'hC3, 1'b1), 11, st);
    repeat (12 * CPB) @(negedge clk);
    n = got_n - base;
    check(n == 1, "R8 count", n, 1);
    if (n >= 1) begin
      check(got_d[base] == 8'hC3, "R8 data", int'(got_d[base]), 'hC3);
      check(got_c[base] - st == LAT, "R8 latency", got_c[base] - st, LAT);
    end

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule